// File: doc/BRIEF.md
# Serial Power Report and Coefficient Link

This block carries two kinds of data over one set of serial wires. It drives a serial clock, a frame strobe and a data-out line, and it samples one data-in line. In each frame it sends a 32-bit unsigned average-power word off chip, most significant bit first. In the same frame it collects a 32-bit reply that holds two 16-bit thermal-compensation coefficients, A and B. The bit rate is derived from the power integrator's period, so one frame of 32 bits lasts exactly one integrator period.

The power integrator, the compensation arithmetic and register decoding sit outside this block and arrive as plain input ports.

- **Transmit and receive enables.** Each direction has its own enable. The serial clock and frame strobe run while either enable is set.
- **Coefficient source.** While receive is off, the coefficient outputs show two fallback inputs instead of received values.
- **Coefficient stream.** Received coefficients leave as a valid-only stream that cannot be stalled. `coef_valid` is high for one system clock when a complete frame has been committed, and `coef_a` and `coef_b` stay put until the next commit. A consumer that needs the values must take them in the pulse cycle or read the held outputs later.
- **Power word input.** The power word is not handshaked. It is sampled once per frame, at the frame start.

Top module: `serial_power_link`

## Requirements
- R1: The transmitted frame carries the power word most significant bit first. Each bit is valid on `sdo` at the rising edge of `sclk` that belongs to it.
- R2: `sync` is high during the whole of bit 0 of every frame, which is one serial-clock period (`2 << period_sel` system clocks), and low during the other bits. `sclk` is low when `sync` rises.
- R3: Frame length and serial clock rate follow `period_sel`:
  - A frame lasts `64 << period_sel` system clocks, that is 64, 128, 256 or 512.
  - Each serial bit lasts `2 << period_sel` system clocks, with `sclk` high for the second half of the bit.
  - `period_sel` is taken at the frame start, so a change during a frame applies from the next frame.
- R4: The power word is captured at the frame start. Changing `pwr_word` during a frame does not alter that frame; the new value goes out in the next frame.
- R5: `sdo` changes only at a falling edge of `sclk`. `sdi` is sampled at the rising edge of `sclk`.
- R6: While `tx_en` is 0, `sdo` stays low. If `rx_en` is 1, `sclk` and `sync` keep running with the normal frame timing.
- R7: While both enables are 0, `sclk` and `sync` stay low. Setting either enable starts a new frame at bit 0, and `sync` is seen high in the first cycle after the enabling clock edge.
- R8: In a received frame the first 16 bits form A, most significant bit first, and the next 16 bits form B, most significant bit first.
- R9: Received coefficients are committed only after all 32 bits of a frame are captured, together with a one-cycle `coef_valid` pulse. A frame during which `rx_en` was 0 at any point is discarded, and the previous values stay.
- R10: While `rx_en` is 0:
  - `coef_a` and `coef_b` show `fb_a` and `fb_b`.
  - `coef_valid` stays low, and `sdi` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_word | input | 32 | Average-power word to transmit |
| period_sel | input | 2 | Integrator period select (64/128/256/512 clocks) |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| fb_a | input | 16 | Fallback coefficient A |
| fb_b | input | 16 | Fallback coefficient B |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sync | output | 1 | Frame strobe, high during bit 0 |
| sdo | output | 1 | Serial data out |
| coef_a | output | 16 | Coefficient A |
| coef_b | output | 16 | Coefficient B |
| coef_valid | output | 1 | One-cycle commit pulse for received coefficients |

## Verification
The assertions check the following on every cycle:
- the idle silence of the serial clock and strobe when both enables are off;
- that the strobe only rises while the serial clock is low;
- that the data-out line holds steady through each high phase of the serial clock;
- that the commit pulse is a single cycle and follows an enabled receive;
- that the coefficients hold between commits.

The bench scenarios show the properties that need a reference value or a whole frame: the bit order of both words, the frame length and bit length for different period selects, when the power word and the period select are captured, that a partial receive frame is discarded, and that the fallback values are selected.

// File: rtl/slk_pkg.sv
package slk_pkg;
  // Per-cycle timing events shared between the frame timer and the shifters.
  typedef struct packed {
    logic run;      // frame machinery active
    logic load;     // next edge starts a new frame
    logic bit_adv;  // next edge ends the current bit (sclk falling)
    logic sample;   // next edge is an sclk rising edge
    logic last_bit; // current bit is the final bit of the frame
  } slk_tick_t;
endpackage

// File: rtl/slk_frame_timer.sv
module slk_frame_timer
  import slk_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int SEL_W      = 2,
  parameter int BASE_DIV   = 2,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [SEL_W-1:0] period_sel,
  output slk_tick_t        tick,
  output logic             sclk,
  output logic             sync
);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q, div, half;
  logic [BIT_W-1:0] bit_q;
  logic [SEL_W-1:0] sel_q;
  logic             run_q;
  logic             last, bit_end;

  assign div     = CNT_W'(BASE_DIV) << sel_q;
  assign half    = div >> 1;
  assign last    = (bit_q == BIT_W'(FRAME_BITS - 1));
  assign bit_end = run_q && (cnt_q == div - 1'b1);

  always_comb begin
    tick.run      = run_q;
    tick.bit_adv  = bit_end;
    tick.last_bit = last;
    tick.sample   = run_q && (cnt_q == half - 1'b1);
    tick.load     = active && (!run_q || (bit_end && last));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      bit_q <= '0;
      sel_q <= '0;
    end else if (!active) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      bit_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (tick.load) begin
        cnt_q <= '0;
        bit_q <= '0;
        sel_q <= period_sel;
      end else if (bit_end) begin
        cnt_q <= '0;
        bit_q <= bit_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk = run_q && (cnt_q >= half);
  assign sync = run_q && (bit_q == '0);
endmodule

// File: rtl/slk_tx_shift.sv
module slk_tx_shift
  import slk_pkg::*;
#(
  parameter int PWR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  slk_tick_t        tick,
  input  logic             tx_en,
  input  logic [PWR_W-1:0] pwr_word,
  output logic             sdo
);
  logic [PWR_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (tick.load) begin
      sh_q <= pwr_word;
    end else if (tick.bit_adv) begin
      sh_q <= {sh_q[PWR_W-2:0], 1'b0};
    end
  end

  assign sdo = tick.run && tx_en && sh_q[PWR_W-1];
endmodule

// File: rtl/slk_rx_capture.sv
module slk_rx_capture
  import slk_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  slk_tick_t         tick,
  input  logic              rx_en,
  input  logic              sdi,
  output logic [COEF_W-1:0] a_q,
  output logic [COEF_W-1:0] b_q,
  output logic              valid_q
);
  localparam int FRAME_BITS = 2 * COEF_W;

  logic [FRAME_BITS-2:0] sh_q;
  logic [FRAME_BITS-1:0] word;
  logic                  good_q, commit;

  assign word   = {sh_q, sdi};
  assign commit = tick.sample && tick.last_bit && good_q && rx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      good_q  <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      if (tick.load) begin
        good_q <= rx_en;
      end else if (!rx_en) begin
        good_q <= 1'b0;
      end
      if (tick.sample && rx_en) begin
        sh_q <= word[FRAME_BITS-2:0];
      end
      valid_q <= commit;
      if (commit) begin
        a_q <= word[FRAME_BITS-1:COEF_W];
        b_q <= word[COEF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/serial_power_link.sv
module serial_power_link
  import slk_pkg::*;
#(
  parameter int PWR_W    = 32,
  parameter int COEF_W   = 16,
  parameter int SEL_W    = 2,
  parameter int BASE_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PWR_W-1:0]  pwr_word,
  input  logic [SEL_W-1:0]  period_sel,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [COEF_W-1:0] fb_a,
  input  logic [COEF_W-1:0] fb_b,
  input  logic              sdi,
  output logic              sclk,
  output logic              sync,
  output logic              sdo,
  output logic [COEF_W-1:0] coef_a,
  output logic [COEF_W-1:0] coef_b,
  output logic              coef_valid
);
  localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DIV) + 1;

  slk_tick_t         tick;
  logic [COEF_W-1:0] rx_a, rx_b;

  slk_frame_timer #(
    .FRAME_BITS(PWR_W), .SEL_W(SEL_W), .BASE_DIV(BASE_DIV), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .active(tx_en || rx_en), .period_sel(period_sel),
    .tick(tick), .sclk(sclk), .sync(sync)
  );

  slk_tx_shift #(.PWR_W(PWR_W)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .tx_en(tx_en),
    .pwr_word(pwr_word), .sdo(sdo)
  );

  slk_rx_capture #(.COEF_W(COEF_W)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx_en(rx_en), .sdi(sdi),
    .a_q(rx_a), .b_q(rx_b), .valid_q(coef_valid)
  );

  assign coef_a = rx_en ? rx_a : fb_a;
  assign coef_b = rx_en ? rx_b : fb_b;
endmodule

// File: rtl/slk_checker.sv
module slk_checker #(
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              rx_en,
  input logic              sclk,
  input logic              sync,
  input logic              sdo,
  input logic [COEF_W-1:0] coef_a,
  input logic [COEF_W-1:0] coef_b,
  input logic              coef_valid
);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !rx_en) |=> (!sclk && !sync));

  p_sync_clk_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sync) |-> !sclk);

  p_sdo_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk) && $stable(tx_en)) |-> $stable(sdo));

  p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
    coef_valid |=> !coef_valid);

  p_valid_needs_rx_r10: assert property (@(posedge clk) disable iff (rst)
    coef_valid |-> $past(rx_en));

  p_coef_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_en && $past(rx_en) && !coef_valid) |-> ($stable(coef_a) && $stable(coef_b)));
endmodule

bind serial_power_link slk_checker #(.COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .sclk(sclk),
  .sync(sync), .sdo(sdo), .coef_a(coef_a), .coef_b(coef_b),
  .coef_valid(coef_valid)
);

// File: tb/sim_serial_power_link.sv
module sim_serial_power_link;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pwr_word = '0;
  logic [1:0]  period_sel = '0;
  logic        tx_en = 1'b0, rx_en = 1'b0, sdi = 1'b0;
  logic [15:0] fb_a = 16'hC0DE, fb_b = 16'h1F2E;
  logic        sclk, sync, sdo, coef_valid;
  logic [15:0] coef_a, coef_b;

  int n_chk = 0, n_fail = 0, ticks = 0;
  bit sclk_s = 0, sync_s = 0, prv_sclk = 0, prv_sync = 0, at_start = 0;

  serial_power_link u0 (
    .clk(clk), .rst(rst), .pwr_word(pwr_word), .period_sel(period_sel),
    .tx_en(tx_en), .rx_en(rx_en), .fb_a(fb_a), .fb_b(fb_b), .sdi(sdi),
    .sclk(sclk), .sync(sync), .sdo(sdo), .coef_a(coef_a), .coef_b(coef_b),
    .coef_valid(coef_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    prv_sclk = sclk_s;
    prv_sync = sync_s;
    @(negedge clk);
    sclk_s = sclk;
    sync_s = sync;
    ticks++;
    if (ticks > WATCHDOG) begin
      chk(0, "WD", "watchdog expired", ticks, WATCHDOG);
      finish_run();
    end
  endtask

  // Runs one frame from a sync rise to the next sync rise, driving sdi with rxw.
  // At bit index at_k the inputs pwr_word, period_sel and rx_en take nw/ns/nr.
  task automatic grab(input logic [31:0] rxw, input int at_k,
                      input logic [31:0] nw, input logic [1:0] ns, input logic nr,
                      output logic [31:0] txb, output int len, output int hi,
                      output int syn, output bit vmid, output bit vend);
    int k;
    bit rise;
    if (!at_start) begin
      do step(); while (!(sync_s && !prv_sync));
    end
    k = 0; len = 0; hi = 0; syn = 1; vmid = 0; vend = 0; txb = '0;
    sdi = rxw[31];
    forever begin
      step();
      len++;
      if (sync_s && !prv_sync) break;
      if (sclk_s) hi++;
      if (sync_s) syn++;
      rise = sclk_s && !prv_sclk;
      if (rise && k < 32) begin
        txb[31-k] = sdo;
        k++;
        if (k == 32) vend = coef_valid;
        else begin
          sdi = rxw[31-k];
          if (coef_valid) vmid = 1;
        end
        if (k == at_k) begin
          pwr_word = nw; period_sel = ns; rx_en = nr;
        end
      end else if (coef_valid) vmid = 1;
    end
    at_start = 1;
  endtask

  logic [31:0] txb;
  int len, hi, syn;
  bit vmid, vend;

  task automatic t_reset();
    repeat (3) step();
    chk(sclk == 0 && sync == 0, "R7", "idle sclk/sync in reset", {sclk, sync}, 0);
    chk(sdo == 0 && coef_valid == 0, "R6", "sdo/valid low in reset", {sdo, coef_valid}, 0);
    rst = 1'b0;
    repeat (4) step();
    chk(sclk == 0 && sync == 0, "R7", "idle after reset", {sclk, sync}, 0);
    chk(coef_a == fb_a && coef_b == fb_b, "R10", "fallback coefs", {coef_a, coef_b}, {fb_a, fb_b});
  endtask

  task automatic t_tx_word(input logic [1:0] sel, input logic [31:0] w);
    pwr_word = w; period_sel = sel; tx_en = 1; rx_en = 0; at_start = 0;
    grab(32'h0, -1, w, sel, 0, txb, len, hi, syn, vmid, vend);
    grab(32'hFFFF_0000, -1, w, sel, 0, txb, len, hi, syn, vmid, vend);
    chk(txb == w, "R1", "tx word msb first", txb, w);
    chk(len == (64 << sel), "R3", "frame length", len, 64 << sel);
    chk(hi == (32 << sel), "R3", "sclk high count", hi, 32 << sel);
    chk(syn == (2 << sel), "R2", "sync width", syn, 2 << sel);
    chk(!vmid && !vend, "R10", "no valid while rx off", {vmid, vend}, 0);
    chk(coef_a == fb_a && coef_b == fb_b, "R10", "fallback with sdi toggling", {coef_a, coef_b}, {fb_a, fb_b});
  endtask

  task automatic t_latch_points();
    logic [31:0] w1 = 32'h1357_9BDF, w2 = 32'hECA8_6420;
    pwr_word = w1; period_sel = 2'd1; tx_en = 1; rx_en = 0; at_start = 0;
    grab(0, -1, w1, 2'd1, 0, txb, len, hi, syn, vmid, vend);
    grab(0, 10, w2, 2'd2, 0, txb, len, hi, syn, vmid, vend);
    chk(txb == w1, "R4", "mid-frame word change ignored", txb, w1);
    chk(len == 128, "R3", "mid-frame sel change ignored", len, 128);
    grab(0, -1, w2, 2'd2, 0, txb, len, hi, syn, vmid, vend);
    chk(txb == w2, "R4", "new word in next frame", txb, w2);
    chk(len == 256, "R3", "new sel in next frame", len, 256);
  endtask

  task automatic t_tx_off();
    pwr_word = 32'hFFFF_FFFF; period_sel = 0; tx_en = 0; rx_en = 1; at_start = 0;
    grab(0, -1, pwr_word, 0, 1, txb, len, hi, syn, vmid, vend);
    grab(0, -1, pwr_word, 0, 1, txb, len, hi, syn, vmid, vend);
    chk(txb == 0, "R6", "sdo low with tx off", txb, 0);
    chk(len == 64 && hi == 32, "R6", "sclk runs with rx only", {len, hi}, {32'd64, 32'd32});
  endtask

  task automatic t_rx_frame(input logic [31:0] rxw);
    grab(rxw, -1, pwr_word, period_sel, 1, txb, len, hi, syn, vmid, vend);
    chk(vend && !vmid, "R9", "single valid at frame end", {vmid, vend}, 1);
    chk(coef_a == rxw[31:16], "R8", "coef A msb first (R5 rising sample)", coef_a, rxw[31:16]);
    chk(coef_b == rxw[15:0], "R8", "coef B msb first", coef_b, rxw[15:0]);
  endtask

  task automatic t_rx_gate();
    rx_en = 0; at_start = 0;
    step();
    chk(coef_a == fb_a && coef_b == fb_b, "R10", "fallback when rx dropped", {coef_a, coef_b}, {fb_a, fb_b});
    grab(32'h5555_AAAA, -1, pwr_word, period_sel, 0, txb, len, hi, syn, vmid, vend);
    chk(!vmid && !vend, "R10", "no valid while rx off", {vmid, vend}, 0);
    grab(32'h5555_AAAA, 10, pwr_word, period_sel, 1, txb, len, hi, syn, vmid, vend);
    chk(!vmid && !vend, "R9", "partial frame no valid", {vmid, vend}, 0);
    chk(coef_a == 16'hFFFF && coef_b == 16'h0001, "R9", "partial frame discarded",
        {coef_a, coef_b}, 32'hFFFF_0001);
    t_rx_frame(32'h0F0F_7777);
  endtask

  task automatic t_idle_restart();
    logic [31:0] w = 32'hDEAD_0B0E;
    tx_en = 0; rx_en = 0; pwr_word = w; period_sel = 0;
    step();
    for (int i = 0; i < 20; i++) begin
      step();
      chk(!sclk_s && !sync_s, "R7", "idle quiet", {sclk_s, sync_s}, 0);
    end
    tx_en = 1;
    step();
    chk(sync_s && !sclk_s, "R7", "frame starts right after enable", {sync_s, sclk_s}, 2'b10);
    at_start = 1;
    grab(0, -1, w, 0, 0, txb, len, hi, syn, vmid, vend);
    chk(txb == w, "R7", "first frame after idle carries word", txb, w);
  endtask

  initial begin
    t_reset();
    t_tx_word(2'd0, 32'hA5C3_0F96);
    t_tx_word(2'd3, 32'h8000_0001);
    t_latch_points();
    t_tx_off();
    period_sel = 0; tx_en = 1; rx_en = 1; at_start = 0;
    t_rx_frame(32'h1234_BEEF);
    t_rx_frame(32'hFFFF_0001);
    t_rx_gate();
    t_idle_restart();
    finish_run();
  end
endmodule